// File: doc/BRIEF.md
# Stereo PCM Serial Audio Formatter

This block turns pairs of 16-bit left and right PCM samples into a three-wire serial audio stream: a word-select clock (LRCK), a bit clock (BCK) and one data line. A sample pair is taken through a valid/ready handshake once per frame, when the left half-frame begins. Three frame layouts are selected by configuration: the I2S layout, MSB-first left-justified and MSB-first right-justified. Each half-frame is 16, 24 or 32 bit-clock periods long, chosen by a slot-length code.

In master clocking the block divides its system clock to make BCK and LRCK. In slave clocking it takes LRCK and BCK from an external receiver, samples them into the system clock domain, and drives the data line in step with them. Slave clocking is meant for a 44.1 kHz frame rate and a system clock well above the bit clock. The clocking mode, format and slot code are static configuration and may only be changed while reset is asserted.

Top module: `aud_ser_fmt`

## Requirements
- R1: While reset is asserted and right after it, `bck_o`, `data_o` and `in_ready` are low, and `lrck_o` shows the right-channel level in master clocking (high for I2S, low for the other formats).
- R2: In master clocking `bck_o` toggles every `BCK_HALF` system clocks, and `lrck_o` changes only in the cycle where `bck_o` falls, after exactly one half-frame of bit periods.
- R3: Format code 0 (I2S): LRCK low marks the left half; the sample MSB is in bit period 1 of its half-frame, bits follow MSB first, the LSB of a 16-bit half falls in bit period 0 of the next half, and remaining periods carry zero.
- R4: Format codes 1 and 3 (left-justified): LRCK high marks the left half; the MSB is in bit period 0 and bits 16 onward carry zero.
- R5: Format code 2 (right-justified): LRCK high marks the left half; the LSB is in the last bit period of the half-frame and every earlier unused period carries zero.
- R6: Slot code 0 gives 16 bit periods per half-frame and code 1 gives 24; codes 2 and 3 give 32 in slave clocking and fall back to 24 in master clocking.
- R7: In master clocking `data_o` changes only in the cycle where `bck_o` falls, so a receiver samples it on the rising edge.
- R8: `in_ready` is high for one cycle at the start of each left half-frame; a pair is accepted if `in_valid` is high then, otherwise that frame carries zeros in both channels.
- R9: In slave clocking a change of `lrck_i` seen at a falling `bck_i` starts a new half-frame, and `data_o` settles no later than three system clocks after each falling `bck_i`.
- R10: In slave clocking `bck_o` and `lrck_o` are held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slave_i | input | 1 | 1 = slave clocking, 0 = master clocking |
| fmt_i | input | 2 | Frame layout: 0 I2S, 1 or 3 left-justified, 2 right-justified |
| slot_i | input | 2 | Half-frame length code: 0 = 16, 1 = 24, 2/3 = 32 (slave) or 24 (master) |
| in_valid | input | 1 | Sample pair present |
| in_ready | output | 1 | Sample pair taken this cycle |
| in_left | input | 16 | Left sample |
| in_right | input | 16 | Right sample |
| lrck_i | input | 1 | External word-select clock (slave) |
| bck_i | input | 1 | External bit clock (slave) |
| lrck_o | output | 1 | Generated word-select clock (master) |
| bck_o | output | 1 | Generated bit clock (master) |
| data_o | output | 1 | Serial data |

## Verification
A wrong bit counter or channel flag shows on the very next bit period: the captured data bit no longer matches the bit the layout places there, or the half-frame length seen between LRCK edges is off by one. A wrong sample register or a lost handshake shows within one frame as a corrupted word or a count of ready pulses that no longer tracks the frames started. Every bit of several frames is compared in each mode, layout and slot length, so such faults surface within the first frame of the affected configuration.

// File: rtl/aud_ser_pkg.sv
package aud_ser_pkg;

  localparam int SAMPLE_W = 16;
  localparam int IDX_W    = 6;

  typedef logic [IDX_W-1:0]    idx_t;
  typedef logic [SAMPLE_W-1:0] word_t;

  typedef enum logic [1:0] {
    FMT_I2S    = 2'd0,
    FMT_LJ     = 2'd1,
    FMT_RJ     = 2'd2,
    FMT_LJ_ALT = 2'd3
  } fmt_e;

  // Bit periods per half-frame for a slot code.
  function automatic idx_t half_len(input logic [1:0] slot, input logic slave);
    case (slot)
      2'd0:    return idx_t'(16);
      2'd1:    return idx_t'(24);
      default: return slave ? idx_t'(32) : idx_t'(24);
    endcase
  endfunction

  // Serial bit for bit period idx of a half-frame.
  function automatic logic chan_bit(input logic [1:0] fmt, input idx_t hl,
                                    input idx_t idx, input word_t cur,
                                    input word_t prior);
    word_t w;
    idx_t  pos;
    idx_t  lead;
    w    = cur;
    pos  = idx;
    lead = hl - idx_t'(SAMPLE_W);
    if (fmt == FMT_I2S) begin
      if (idx == '0) begin
        w   = prior;
        pos = hl - idx_t'(1);
      end else begin
        pos = idx - idx_t'(1);
      end
    end else if (fmt == FMT_RJ) begin
      if (idx < lead) begin
        w   = '0;
        pos = idx;
      end else begin
        pos = idx - lead;
      end
    end
    w = w << pos;
    return w[SAMPLE_W-1];
  endfunction

endpackage

// File: rtl/aud_ser_bckgen.sv
module aud_ser_bckgen #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic bck,
  output logic fall
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap = (cnt == CW'(HALF - 1));
  assign fall = en & wrap & bck;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      bck <= 1'b0;
    end else if (!en) begin
      cnt <= '0;
      bck <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      bck <= ~bck;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/aud_ser_slvsync.sv
module aud_ser_slvsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bck_in,
  input  logic lrck_in,
  output logic fall,
  output logic lrck_s
);
  logic [STAGES:0]   bck_sh;
  logic [STAGES-1:0] lr_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bck_sh <= '0;
      lr_sh  <= '0;
    end else begin
      bck_sh <= {bck_sh[STAGES-1:0], bck_in};
      lr_sh  <= {lr_sh[STAGES-2:0], lrck_in};
    end
  end

  assign fall   = bck_sh[STAGES] & ~bck_sh[STAGES-1];
  assign lrck_s = lr_sh[STAGES-1];
endmodule

// File: rtl/aud_ser_frame.sv
module aud_ser_frame
  import aud_ser_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       evt,
  input  logic       slave,
  input  logic       ext_side,
  input  logic [1:0] fmt,
  input  idx_t       hl,
  input  logic       in_valid,
  input  word_t      in_left,
  input  word_t      in_right,
  output logic       load,
  output logic       side,
  output logic       data
);
  idx_t  idx, idx_n;
  word_t cur_l, cur_r, prev_r;
  word_t cur_l_n, cur_r_n, prev_r_n, word_n, prior_n;
  logic  new_half, side_n;

  always_comb begin
    new_half = slave ? (ext_side != side) : (idx >= hl - idx_t'(1));
    side_n   = new_half ? (slave ? ext_side : ~side) : side;
    idx_n    = new_half ? '0 : ((idx == '1) ? idx : idx + idx_t'(1));
    load     = evt & new_half & ~side_n;
    cur_l_n  = load ? (in_valid ? in_left  : '0) : cur_l;
    cur_r_n  = load ? (in_valid ? in_right : '0) : cur_r;
    prev_r_n = load ? cur_r : prev_r;
    word_n   = side_n ? cur_r_n : cur_l_n;
    prior_n  = side_n ? cur_l_n : prev_r_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx    <= '1;
      side   <= 1'b1;
      cur_l  <= '0;
      cur_r  <= '0;
      prev_r <= '0;
      data   <= 1'b0;
    end else if (evt) begin
      idx    <= idx_n;
      side   <= side_n;
      cur_l  <= cur_l_n;
      cur_r  <= cur_r_n;
      prev_r <= prev_r_n;
      data   <= chan_bit(fmt, hl, idx_n, word_n, prior_n);
    end
  end
endmodule

// File: rtl/aud_ser_fmt.sv
module aud_ser_fmt
  import aud_ser_pkg::*;
#(
  parameter int BCK_HALF    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        slave_i,
  input  logic [1:0]  fmt_i,
  input  logic [1:0]  slot_i,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [15:0] in_left,
  input  logic [15:0] in_right,
  input  logic        lrck_i,
  input  logic        bck_i,
  output logic        lrck_o,
  output logic        bck_o,
  output logic        data_o
);
  logic m_bck, m_fall, s_fall, s_lrck;
  logic bit_evt, side, not_i2s, ext_side;
  idx_t hl;

  assign not_i2s  = (fmt_i != FMT_I2S);
  assign hl       = half_len(slot_i, slave_i);
  assign bit_evt  = slave_i ? s_fall : m_fall;
  assign ext_side = s_lrck ^ not_i2s;

  aud_ser_bckgen #(.HALF(BCK_HALF)) u_bck (
    .clk(clk), .rst_n(rst_n), .en(~slave_i), .bck(m_bck), .fall(m_fall)
  );

  aud_ser_slvsync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .bck_in(bck_i), .lrck_in(lrck_i),
    .fall(s_fall), .lrck_s(s_lrck)
  );

  aud_ser_frame u_frame (
    .clk(clk), .rst_n(rst_n), .evt(bit_evt), .slave(slave_i),
    .ext_side(ext_side), .fmt(fmt_i), .hl(hl), .in_valid(in_valid),
    .in_left(in_left), .in_right(in_right), .load(in_ready),
    .side(side), .data(data_o)
  );

  assign bck_o  = slave_i ? 1'b0 : m_bck;
  assign lrck_o = slave_i ? 1'b0 : (side ^ not_i2s);
endmodule

// File: rtl/aud_ser_fmt_chk.sv
module aud_ser_fmt_chk (
  input logic clk,
  input logic rst_n,
  input logic slave,
  input logic evt,
  input logic bck,
  input logic lrck,
  input logic data,
  input logic ready
);
  // R7: data moves only with a falling bit clock in master clocking
  a_r7_data_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (!slave && !$stable(data)) |-> $fell(bck));

  // R2: word select moves only with a falling bit clock
  a_r2_lrck_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (!slave && !$stable(lrck)) |-> $fell(bck));

  // R2: every bit event of the divider is followed by a low bit clock
  a_r2_evt_drops_bck: assert property (@(posedge clk) disable iff (!rst_n)
    (!slave && evt) |=> $fell(bck));

  // R8: ready is a single-cycle pulse
  a_r8_ready_single: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready);

  // R10: generated clocks are quiet in slave clocking
  a_r10_slave_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    slave |-> (!bck && !lrck));
endmodule

bind aud_ser_fmt aud_ser_fmt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .slave(slave_i), .evt(bit_evt),
  .bck(bck_o), .lrck(lrck_o), .data(data_o), .ready(in_ready)
);

// File: tb/aud_ser_fmt_test.sv
module aud_ser_fmt_test;
  localparam int BH = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slave_i = 1'b0;
  logic [1:0]  fmt_i = 2'd0;
  logic [1:0]  slot_i = 2'd0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_left = '0;
  logic [15:0] in_right = '0;
  logic        lrck_i = 1'b0;
  logic        bck_i = 1'b0;
  logic        lrck_o, bck_o, data_o;

  int vectors = 0;
  int miscompares = 0;
  int total_cyc = 0;

  logic [15:0] acc_l [0:63];
  logic [15:0] acc_r [0:63];

  always #2 clk = ~clk;

  aud_ser_fmt #(.BCK_HALF(BH)) uut (
    .clk(clk), .rst_n(rst_n), .slave_i(slave_i), .fmt_i(fmt_i),
    .slot_i(slot_i), .in_valid(in_valid), .in_ready(in_ready),
    .in_left(in_left), .in_right(in_right), .lrck_i(lrck_i), .bck_i(bck_i),
    .lrck_o(lrck_o), .bck_o(bck_o), .data_o(data_o)
  );

  function automatic logic [15:0] wl(input int k);
    return 16'((k * 40503 + 33825) & 16'hFFFF);
  endfunction

  function automatic logic [15:0] wr(input int k);
    return wl(k + 17) ^ 16'h5A5A;
  endfunction

  // Expected bit from the format rules, written independently.
  function automatic logic exp_bit(input int f, input int hl, input int i,
                                   input logic [15:0] cur, input logic [15:0] prior);
    int s;
    if (f == 0) begin
      if (i == 0) return (hl == 16) ? prior[0] : 1'b0;
      return (i <= 16) ? cur[16 - i] : 1'b0;
    end else if (f == 2) begin
      s = hl - 16;
      if (i < s) return 1'b0;
      return (i - s < 16) ? cur[15 - (i - s)] : 1'b0;
    end
    return (i < 16) ? cur[15 - i] : 1'b0;
  endfunction

  function automatic string ftag(input int f);
    if (f == 0) return "R3";
    if (f == 2) return "R5";
    return "R4";
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic run_cfg(input bit slv, input int f, input int s, input int drop);
    int  hl, accn, rframe, ridx, rside, cyc, c, sidx, sside, lastrise, side;
    bit  took, pb, got, have_half, lv, dv, ok, done;
    logic [15:0] cur, prior;
    hl = (s == 0) ? 16 : (s == 1) ? 24 : (slv ? 32 : 24);
    rst_n = 1'b0;
    slave_i = slv;
    fmt_i = 2'(f);
    slot_i = 2'(s);
    in_left = wl(0);
    in_right = wr(0);
    in_valid = (drop != 0);
    sside = 1;
    lrck_i = 1'(sside) ^ (f != 0);
    bck_i = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(bck_o == 1'b0 && data_o == 1'b0 && in_ready == 1'b0, "R1 reset outputs",
          {bck_o, data_o, in_ready}, 0);
    check(lrck_o == (slv ? 1'b0 : (f == 0)), "R1 reset lrck", lrck_o, slv ? 0 : (f == 0));
    rst_n = 1'b1;
    @(negedge clk);
    check(bck_o == 1'b0 && data_o == 1'b0 && in_ready == 1'b0, "R1 after release",
          {bck_o, data_o, in_ready}, 0);
    took = 0; pb = 0; have_half = 0; done = 0;
    accn = 0; rframe = -1; ridx = 0; rside = 1; cyc = 0; c = 6;
    sidx = hl - 1; lastrise = -1;
    while (!done) begin
      @(negedge clk);
      cyc++;
      total_cyc++;
      // driver
      if (took) begin
        in_left = wl(accn);
        in_right = wr(accn);
        in_valid = (accn != drop);
        took = 0;
      end
      if (in_ready) begin
        acc_l[accn] = in_valid ? in_left : 16'h0;
        acc_r[accn] = in_valid ? in_right : 16'h0;
        accn++;
        took = 1;
      end
      // receiver
      got = 0;
      lv = 0;
      dv = 0;
      if (!slv) begin
        if (bck_o && !pb) begin
          got = 1;
          lv = lrck_o;
          dv = data_o;
          if (lastrise >= 0)
            check(cyc - lastrise == 2 * BH, "R2 bck period", cyc - lastrise, 2 * BH);
          lastrise = cyc;
        end
        pb = bck_o;
      end else begin
        if (c == 5) begin
          got = 1;
          lv = lrck_i;
          dv = data_o;
          bck_i = 1'b1;
          check(bck_o == 1'b0 && lrck_o == 1'b0, "R10 slave outputs quiet",
                {bck_o, lrck_o}, 0);
        end else if (c == 11) begin
          bck_i = 1'b0;
          sidx++;
          if (sidx == hl) begin
            sidx = 0;
            sside = 1 - sside;
            lrck_i = 1'(sside) ^ (f != 0);
          end
        end
        c = (c == 11) ? 0 : c + 1;
      end
      if (got) begin
        side = int'(lv ^ (f != 0));
        if (side != rside) begin
          if (have_half)
            check(ridx == hl - 1, slv ? "R9 R6 half length" : "R6 half length", ridx + 1, hl);
          have_half = 1;
          rside = side;
          ridx = 0;
          if (side == 0) rframe++;
        end else begin
          ridx++;
        end
        if (rframe >= 4) begin
          done = 1;
        end else if (rframe >= 0) begin
          cur = side ? acc_r[rframe] : acc_l[rframe];
          prior = side ? acc_l[rframe] : ((rframe > 0) ? acc_r[rframe - 1] : 16'h0);
          ok = (dv == exp_bit(f, hl, ridx, cur, prior));
          vectors++;
          if (!ok) begin
            miscompares++;
            $display("FAIL %s%s%s bit cfg slv=%0d fmt=%0d slot=%0d frame=%0d idx=%0d actual=%0d expected=%0d",
                     ftag(f), (rframe == drop) ? " R8" : "", slv ? " R9" : " R7",
                     slv, f, s, rframe, ridx, dv, exp_bit(f, hl, ridx, cur, prior));
          end
        end
      end
      if (cyc > 20000) begin
        miscompares++;
        $display("FAIL watchdog cfg slv=%0d fmt=%0d slot=%0d actual=%0d expected=%0d",
                 slv, f, s, cyc, 20000);
        done = 1;
      end
    end
    // R8: one ready pulse per frame started
    check(accn == rframe + 1, "R8 ready count", accn, rframe + 1);
  endtask

  initial begin
    for (int f = 0; f < 3; f++)
      for (int s = 0; s < 3; s++)
        run_cfg(1'b0, f, s, (s == 1) ? 2 : -1);
    run_cfg(1'b0, 3, 0, -1);
    for (int f = 0; f < 3; f++)
      for (int s = 0; s < 3; s++)
        run_cfg(1'b1, f, s, (s == 2) ? 1 : -1);
    run_cfg(1'b1, 2, 3, -1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #1000000;
    miscompares++;
    $display("FAIL global watchdog actual=%0d expected=%0d", total_cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule